// File: doc/BRIEF.md
# Multicore Interrupt Distributor

This block spreads a set of external interrupt lines across the cores of a small multiprocessor. Each line has its own routing mask that selects the cores it reaches. A global per-line enable can be set or cleared by mask, so software can change one line without a read-modify-write. Software can also force a line active through an assert mask, in the same way an asserted input would.

The block also carries inter-processor signalling. Each core has a cause register of sixteen bits, and any set bit raises that core's single inter-processor request. Any agent can raise one cause number on several cores with a single write of a core mask. The target core clears its own bits by writing ones to them.

The remaining registers hold a read-only configuration word, an 8-bit partition value, a per-core run-stall mask that drives the stall pins, and a cache-coherency enable. Access is through one synchronous word-addressed write port and a combinational read port.

Top module: `irq_distributor`

## Requirements
- R1: After reset, the following are zero: all enables, routing masks, cause bits, assert bits, the partition register and the coherency bit, and every request output is low. The run-stall mask resets to all ones except bit 0, so only core 0 runs.
- R2: Word address n, for n below the line count, holds the routing mask of line n in bits [NCORES-1:0], and the unused upper bits read zero. Bit p of `core_ext_irq[p*NLINES+n]` is high only while line n is enabled, line n is active (its input is high or its assert bit is set), and bit p of its routing mask is set.
- R3: A write to 0x180 clears the enable bits that are set in the written mask and leaves the other bits unchanged. A read of 0x180 returns the enable mask.
- R4: A write to 0x184 sets the enable bits that are set in the written mask and leaves the other bits unchanged. A read of 0x184 also returns the enable mask.
- R5: A write to 0x18C sets assert bits by mask, and a write to 0x188 clears them by mask. A read of 0x188 returns the assert mask. An enabled and routed line with its assert bit set is delivered while its input is low.
- R6: A write of core mask m to 0x140+c sets cause bit c in the cause register of every core p that has bit p set in m. Addresses in this range read zero.
- R7: The cause register of core p reads at 0x100+p. Writing a 1 to a bit position there clears that bit (write-one-to-clear), and zero bits have no effect. `core_ipi[p]` is the OR of core p's cause bits.
- R8: Address 0x1A0 reads the constant {VERSION[9:0], NCORES-1 in 4 bits, CFG_ID[17:0]}, with the version field in the top bits. Writes to it have no effect.
- R9: Address 0x190 holds an 8-bit partition value in bits [7:0], and bits [31:8] read zero.
- R10: Address 0x200 holds the run-stall mask, and bit p drives `run_stall[p]`. Address 0x220 holds the coherency enable in bit 0, which drives `coherency_en`.
- R11: Reads of unmapped addresses return zero, and writes to them change no state. This includes routing entries at or beyond NLINES, cause entries at or beyond NCORES, and raise entries at or beyond 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 10 | Word address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| ext_irq | input | NLINES | External interrupt lines, active high |
| core_ext_irq | output | NCORES*NLINES | Routed line requests, core-major |
| core_ipi | output | NCORES | Inter-processor request per core |
| run_stall | output | NCORES | Run-stall per core |
| coherency_en | output | 1 | Cache-coherency enable |

## Verification
The bench builds the block with its defaults: 4 cores, 16 lines and a configuration word with version 0x2A5 and ID 0x1C0DE. With 4 cores, a raise mask can select a non-trivial subset of cores, and the core-count field of the configuration word reads 3. With 16 lines, address 0x010 is the first unmapped routing entry, 0x104 is the first unmapped cause entry and 0x150 is the first unmapped raise entry, so every edge of the address decode is probed. Because the enable mask fills 16 bits, partial set and clear masks on both halves can be told apart.

// File: rtl/irq_distributor.sv
module irq_distributor #(
  parameter int NCORES  = 4,
  parameter int NLINES  = 16,
  parameter int AW      = 10,
  parameter int DW      = 32,
  parameter logic [9:0]  VERSION = 10'h2A5,
  parameter logic [17:0] CFG_ID  = 18'h1C0DE
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  input  logic [NLINES-1:0]        ext_irq,
  output logic [NCORES*NLINES-1:0] core_ext_irq,
  output logic [NCORES-1:0]        core_ipi,
  output logic [NCORES-1:0]        run_stall,
  output logic                     coherency_en
);
  localparam int NCAUSE = 16;
  localparam logic [AW-1:0] A_CAUSE  = AW'(12'h100);
  localparam logic [AW-1:0] A_RAISE  = AW'(12'h140);
  localparam logic [AW-1:0] A_ENCLR  = AW'(12'h180);
  localparam logic [AW-1:0] A_ENSET  = AW'(12'h184);
  localparam logic [AW-1:0] A_ASCLR  = AW'(12'h188);
  localparam logic [AW-1:0] A_ASSET  = AW'(12'h18C);
  localparam logic [AW-1:0] A_PART   = AW'(12'h190);
  localparam logic [AW-1:0] A_CFG    = AW'(12'h1A0);
  localparam logic [AW-1:0] A_STALL  = AW'(12'h200);
  localparam logic [AW-1:0] A_COH    = AW'(12'h220);
  localparam logic [NCORES-1:0] STALL_RST = ~NCORES'(1);
  localparam logic [DW-1:0] CFG_WORD = {VERSION, 4'(NCORES - 1), CFG_ID};

  logic [NCORES-1:0] route_q [NLINES];
  logic [NCAUSE-1:0] cause_q [NCORES];
  logic [NLINES-1:0] en_q, asrt_q, line_live;
  logic [7:0]        part_q;
  logic [NCORES-1:0] stall_q;
  logic              coh_q;

  logic hit_route, hit_cause, hit_raise, hit_fixed, any_hit;
  logic [AW-1:0] cause_idx, raise_idx;
  logic unused_wdata;

  assign unused_wdata = ^wdata;
  assign cause_idx = addr - A_CAUSE;
  assign raise_idx = addr - A_RAISE;
  assign hit_route = addr < AW'(NLINES);
  assign hit_cause = addr >= A_CAUSE && cause_idx < AW'(NCORES);
  assign hit_raise = addr >= A_RAISE && raise_idx < AW'(NCAUSE);
  assign hit_fixed = addr inside {A_ENCLR, A_ENSET, A_ASCLR, A_ASSET, A_PART, A_CFG, A_STALL, A_COH};
  assign any_hit   = hit_route | hit_cause | hit_raise | hit_fixed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NLINES; n++) route_q[n] <= '0;
    end else if (wr_en && hit_route) begin
      for (int n = 0; n < NLINES; n++)
        if (addr == AW'(n)) route_q[n] <= wdata[NCORES-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NCORES; p++) cause_q[p] <= '0;
    end else if (wr_en) begin
      for (int p = 0; p < NCORES; p++)
        for (int c = 0; c < NCAUSE; c++) begin
          if (hit_cause && cause_idx == AW'(p) && wdata[c]) cause_q[p][c] <= 1'b0;
          if (hit_raise && raise_idx == AW'(c) && wdata[p]) cause_q[p][c] <= 1'b1;
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      asrt_q  <= '0;
      part_q  <= '0;
      stall_q <= STALL_RST;
      coh_q   <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_ENCLR: en_q    <= en_q & ~wdata[NLINES-1:0];
        A_ENSET: en_q    <= en_q | wdata[NLINES-1:0];
        A_ASCLR: asrt_q  <= asrt_q & ~wdata[NLINES-1:0];
        A_ASSET: asrt_q  <= asrt_q | wdata[NLINES-1:0];
        A_PART:  part_q  <= wdata[7:0];
        A_STALL: stall_q <= wdata[NCORES-1:0];
        A_COH:   coh_q   <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_route) begin
      for (int n = 0; n < NLINES; n++)
        if (addr == AW'(n)) rdata[NCORES-1:0] = route_q[n];
    end else if (hit_cause) begin
      for (int p = 0; p < NCORES; p++)
        if (cause_idx == AW'(p)) rdata[NCAUSE-1:0] = cause_q[p];
    end else begin
      case (addr)
        A_ENCLR, A_ENSET: rdata[NLINES-1:0] = en_q;
        A_ASCLR:          rdata[NLINES-1:0] = asrt_q;
        A_PART:           rdata[7:0]        = part_q;
        A_CFG:            rdata             = CFG_WORD;
        A_STALL:          rdata[NCORES-1:0] = stall_q;
        A_COH:            rdata[0]          = coh_q;
        default:          rdata             = '0;
      endcase
    end
  end

  assign line_live    = (ext_irq | asrt_q) & en_q;
  assign run_stall    = stall_q;
  assign coherency_en = coh_q;

  for (genvar p = 0; p < NCORES; p++) begin : g_core
    assign core_ipi[p] = |cause_q[p];
    for (genvar n = 0; n < NLINES; n++) begin : g_line
      assign core_ext_irq[p*NLINES+n] = line_live[n] & route_q[n][p];
    end
  end

  p_enclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ENCLR) |=> (en_q & $past(wdata[NLINES-1:0])) == '0);

  p_enset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ENSET) |=> (en_q & $past(wdata[NLINES-1:0])) == $past(wdata[NLINES-1:0]));

  p_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_raise && wdata[0]) |=> core_ipi[0]);

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_cause && cause_idx == '0) |=> (cause_q[0] & $past(wdata[NCAUSE-1:0])) == '0);

  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !any_hit) |=> ($stable(en_q) && $stable(asrt_q) && $stable(part_q)
                             && $stable(stall_q) && $stable(coh_q) && $stable(core_ipi)));

  p_unmapped_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> rdata == '0);
endmodule

// File: tb/irq_distributor_test.sv
module irq_distributor_test;
  localparam int NC = 4;
  localparam int NL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NL-1:0] ext_irq = '0;
  logic [NC*NL-1:0] core_ext_irq;
  logic [NC-1:0] core_ipi, run_stall;
  logic coherency_en;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_distributor uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_irq(ext_irq), .core_ext_irq(core_ext_irq),
    .core_ipi(core_ipi), .run_stall(run_stall), .coherency_en(coherency_en)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(string req, logic [9:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, 64'(rdata), 64'(exp));
  endtask

  task automatic t_reset;
    rd_check("R1 enable", 10'h180, 0);
    rd_check("R1 route0", 10'h000, 0);
    rd_check("R1 cause3", 10'h103, 0);
    rd_check("R1 assert", 10'h188, 0);
    rd_check("R1 partition", 10'h190, 0);
    rd_check("R1 coherency", 10'h220, 0);
    rd_check("R1 stall reg", 10'h200, 32'hE);
    check("R1 run_stall pins", 64'(run_stall), 64'hE);
    check("R1 outputs", core_ext_irq, 64'h0);
    check("R1 ipi", 64'(core_ipi), 64'h0);
  endtask

  task automatic t_route;
    logic [63:0] exp;
    wr(10'h003, 32'hFFFF_FFF5);
    rd_check("R2 route readback", 10'h003, 32'h5);
    ext_irq = 16'h0008;
    #1 check("R2 gated by enable", core_ext_irq, 64'h0);
    wr(10'h184, 32'h0008);
    exp = '0; exp[0*NL+3] = 1'b1; exp[2*NL+3] = 1'b1;
    #1 check("R2 delivered to cores 0,2", core_ext_irq, exp);
    ext_irq = 16'h0000;
    #1 check("R2 input low", core_ext_irq, 64'h0);
    ext_irq = 16'h0008;
    wr(10'h003, 32'h0);
    #1 check("R2 route cleared", core_ext_irq, 64'h0);
    wr(10'h003, 32'h2);
    exp = '0; exp[1*NL+3] = 1'b1;
    #1 check("R2 rerouted to core 1", core_ext_irq, exp);
  endtask

  task automatic t_enable;
    wr(10'h184, 32'h00FF);
    rd_check("R4 set merges", 10'h180, 32'h00FF);
    wr(10'h180, 32'h000F);
    rd_check("R3 clear by mask", 10'h180, 32'h00F0);
    check("R3 line 3 dropped", core_ext_irq, 64'h0);
    wr(10'h184, 32'hFF00);
    rd_check("R4 set upper half", 10'h184, 32'hFFF0);
  endtask

  task automatic t_assert;
    logic [63:0] exp;
    ext_irq = '0;
    wr(10'h005, 32'h8);
    wr(10'h18C, 32'h0020);
    rd_check("R5 assert readback", 10'h188, 32'h0020);
    exp = '0; exp[3*NL+5] = 1'b1;
    check("R5 forced line delivered", core_ext_irq, exp);
    wr(10'h188, 32'h0020);
    rd_check("R5 assert cleared", 10'h188, 32'h0);
    check("R5 forced line gone", core_ext_irq, 64'h0);
  endtask

  task automatic t_ipi;
    wr(10'h147, 32'h6);
    rd_check("R6 core1 cause", 10'h101, 32'h0080);
    rd_check("R6 core2 cause", 10'h102, 32'h0080);
    rd_check("R6 core0 untouched", 10'h100, 32'h0);
    check("R6 ipi pins", 64'(core_ipi), 64'h6);
    rd_check("R6 raise reads zero", 10'h147, 32'h0);
    wr(10'h142, 32'h2);
    rd_check("R6 second cause", 10'h101, 32'h0084);
    wr(10'h101, 32'h0080);
    rd_check("R7 w1c one bit", 10'h101, 32'h0004);
    check("R7 ipi still high", 64'(core_ipi), 64'h6);
    wr(10'h101, 32'h0004);
    rd_check("R7 w1c last bit", 10'h101, 32'h0);
    check("R7 ipi core1 low", 64'(core_ipi), 64'h4);
    wr(10'h102, 32'hFFFF);
    check("R7 all clear", 64'(core_ipi), 64'h0);
  endtask

  task automatic t_config;
    logic [31:0] exp;
    exp = (32'h2A5 << 22) | (32'(NC - 1) << 18) | 32'h1C0DE;
    rd_check("R8 config word", 10'h1A0, exp);
    wr(10'h1A0, 32'h0);
    rd_check("R8 config read-only", 10'h1A0, exp);
  endtask

  task automatic t_misc;
    wr(10'h190, 32'hFFFF_F1A5);
    rd_check("R9 partition 8 bits", 10'h190, 32'hA5);
    wr(10'h200, 32'h5);
    rd_check("R10 stall reg", 10'h200, 32'h5);
    check("R10 stall pins", 64'(run_stall), 64'h5);
    wr(10'h220, 32'h3);
    rd_check("R10 coherency reg", 10'h220, 32'h1);
    check("R10 coherency pin", 64'(coherency_en), 64'h1);
  endtask

  task automatic t_unmapped;
    wr(10'h140, 32'hF);
    rd_check("R11 line16 reads zero", 10'h010, 0);
    rd_check("R11 cause4 reads zero", 10'h104, 0);
    rd_check("R11 raise16 reads zero", 10'h150, 0);
    rd_check("R11 top reads zero", 10'h3FF, 0);
    rd_check("R11 gap reads zero", 10'h181, 0);
    wr(10'h010, 32'hFFFF_FFFF);
    wr(10'h104, 32'hFFFF_FFFF);
    wr(10'h150, 32'hFFFF_FFFF);
    wr(10'h181, 32'hFFFF_FFFF);
    wr(10'h3FF, 32'hFFFF_FFFF);
    rd_check("R11 enable kept", 10'h180, 32'hFFF0);
    rd_check("R11 partition kept", 10'h190, 32'hA5);
    rd_check("R11 stall kept", 10'h200, 32'h5);
    rd_check("R11 assert kept", 10'h188, 32'h0);
    for (int p = 0; p < NC; p++)
      rd_check("R11 cause kept", 10'h100 + 10'(p), 32'h1);
    rd_check("R11 route15 kept", 10'h00F, 32'h0);
    rd_check("R11 route3 kept", 10'h003, 32'h2);
    check("R11 ipi kept", 64'(core_ipi), 64'hF);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_route();
    t_enable();
    t_assert();
    t_ipi();
    t_config();
    t_misc();
    t_unmapped();
    done = 1;
    report();
  end
endmodule